// File: doc/BRIEF.md
# Exception and Privilege Control Unit

This block sits next to a simple in-order core and owns everything about exceptions and privilege. The core presents a vector of exception request lines, each with its own cause code, together with the PC of the current instruction and any faulting virtual address. When an unmasked request is present, the unit asks the core to redirect fetch to a fixed handler address. It records the return PC, the cause and, for address errors, the bad address. It also switches the core into privileged mode.

The core also forwards three decoded system operations: read a control register, write a control register, and return from exception. Each operation carries a register index and write data. These operations are legal only in privileged mode. If one is attempted in user mode, it is converted into an illegal-instruction exception. Return from exception drops back to user mode and redirects fetch to the saved PC.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the unit is privileged (`priv_o`=1), the mask holds all ones, and the cause, saved-PC and bad-address registers read zero.
- R2: A taken exception raises `redirect_o` in the same cycle with `redirect_pc_o` = `HANDLER_ADDR`, and `priv_o` is 1 from the next cycle on.
- R3: When several unmasked lines request at once, only the lowest-numbered one is taken, and its cause code is what index 13 returns afterwards.
- R4: Bit i of the mask (index 12, bits [NUM_SRC-1:0]) enables line i. A request on a masked line causes no redirect and changes no register.
- R5: On a taken exception, index 14 captures `exc_pc_i` of that cycle.
- R6: Index 8 captures `exc_vaddr_i` only when the taken cause is 4 (address error). Any other cause leaves it unchanged.
- R7: `op_i` is encoded as 0 none, 1 read, 2 write, 3 return. A privileged read returns the following on `rdata_o` in the same cycle:
  - index 12: the mode bit at bit 31 and the mask in the low bits;
  - index 13: the cause, zero-extended;
  - indices 8 and 14: the stored bad address and saved PC;
  - any other index: zero.
- R8: A privileged write to index 12 replaces the mask from the low bits of `cp_wdata_i`. Writes to indices 8, 13 and 14 are ignored.
- R9: A privileged return raises `redirect_o` with `redirect_pc_o` equal to the saved PC, and `priv_o` is 0 from the next cycle on.
- R10: Any of the three operations in user mode sets `priv_viol_o`, forces `rdata_o` to zero and performs no access. It takes an illegal-instruction exception instead: cause 10, saved PC from `exc_pc_i`, handler redirect. This exception outranks every request line regardless of the mask.
- R11: In a cycle where an exception is taken, a concurrent write or return is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | NUM_SRC | Exception request lines, line 0 highest priority |
| exc_cause_i | input | NUM_SRC*CAUSE_W | Cause code per line, line i at bits [i*CAUSE_W +: CAUSE_W] |
| exc_pc_i | input | XLEN | PC of the current instruction |
| exc_vaddr_i | input | XLEN | Faulting virtual address |
| op_i | input | 2 | System operation: 0 none, 1 read, 2 write, 3 return |
| cp_idx_i | input | 5 | Control register index |
| cp_wdata_i | input | XLEN | Write data for a control register write |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | XLEN | Redirect target |
| rdata_o | output | XLEN | Read data for a control register read |
| priv_o | output | 1 | 1 = privileged mode |
| priv_viol_o | output | 1 | System operation attempted in user mode |

## Verification
The bench builds the unit with its defaults: four request lines, 4-bit causes and a 32-bit word. With four lines, all 16 mask values can be crossed with all 16 request patterns. The lines carry causes ordered opposite to their priority, so the priority and mask logic is covered exhaustively. Saved PC, cause and bad-address retention are read back after every pattern. Directed sequences then cover the mode transitions, the user-mode conversions and the collisions between an operation and a request.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CP_IDX_W = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MFC0 = 2'd1,
    OP_MTC0 = 2'd2,
    OP_RFE  = 2'd3
  } sys_op_e;

  localparam logic [CP_IDX_W-1:0] IDX_VADDR  = 5'd8;
  localparam logic [CP_IDX_W-1:0] IDX_STATUS = 5'd12;
  localparam logic [CP_IDX_W-1:0] IDX_CAUSE  = 5'd13;
  localparam logic [CP_IDX_W-1:0] IDX_EPC    = 5'd14;

  localparam int CAUSE_ADDR_ERR = 4;
  localparam int CAUSE_ILLEGAL  = 10;
endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int NUM_SRC = 4,
  parameter int CAUSE_W = 4
) (
  input  logic [NUM_SRC-1:0]         req_i,
  input  logic [NUM_SRC*CAUSE_W-1:0] causes_i,
  input  logic [NUM_SRC-1:0]         mask_i,
  output logic                       hit_o,
  output logic [CAUSE_W-1:0]         cause_o
);
  logic [CAUSE_W-1:0] cause_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign cause_arr[g] = causes_i[g*CAUSE_W +: CAUSE_W];
  end

  // scan downward so the lowest enabled line wins
  always_comb begin
    hit_o   = 1'b0;
    cause_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && mask_i[i]) begin
        hit_o   = 1'b1;
        cause_o = cause_arr[i];
      end
    end
  end
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int XLEN    = 32,
  parameter int NUM_SRC = 4,
  parameter int CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [CAUSE_W-1:0] take_cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    vaddr_i,
  input  logic               wr_mask_i,
  input  logic [NUM_SRC-1:0] wdata_mask_i,
  input  logic               rfe_i,
  output logic               priv_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    vaddr_o
);
  import exc_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_o  <= 1'b1;
      mask_o  <= '1;
      cause_o <= '0;
      epc_o   <= '0;
      vaddr_o <= '0;
    end else if (take_i) begin
      priv_o  <= 1'b1;
      cause_o <= take_cause_i;
      epc_o   <= pc_i;
      if (take_cause_i == CAUSE_W'(CAUSE_ADDR_ERR)) vaddr_o <= vaddr_i;
    end else begin
      if (wr_mask_i) mask_o <= wdata_mask_i;
      if (rfe_i)     priv_o <= 1'b0;
    end
  end

  // R2
  take_sets_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> priv_o);
  // R5
  epc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> epc_o == $past(pc_i));
  // R6
  vaddr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && take_cause_i != CAUSE_W'(CAUSE_ADDR_ERR)) |=> $stable(vaddr_o));
  // R9
  rfe_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !take_i) |=> !priv_o);
  // R11
  take_blocks_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> $stable(mask_o));
endmodule

// File: rtl/exc_rdmux.sv
module exc_rdmux #(
  parameter int XLEN    = 32,
  parameter int NUM_SRC = 4,
  parameter int CAUSE_W = 4
) (
  input  logic                         en_i,
  input  logic [exc_pkg::CP_IDX_W-1:0] idx_i,
  input  logic                         priv_i,
  input  logic [NUM_SRC-1:0]           mask_i,
  input  logic [CAUSE_W-1:0]           cause_i,
  input  logic [XLEN-1:0]              epc_i,
  input  logic [XLEN-1:0]              vaddr_i,
  output logic [XLEN-1:0]              rdata_o
);
  import exc_pkg::*;

  logic [XLEN-1:0] status;

  always_comb begin
    status                = '0;
    status[XLEN-1]        = priv_i;
    status[NUM_SRC-1:0]   = mask_i;
  end

  always_comb begin
    rdata_o = '0;
    if (en_i) begin
      case (idx_i)
        IDX_VADDR:  rdata_o = vaddr_i;
        IDX_STATUS: rdata_o = status;
        IDX_CAUSE:  rdata_o = XLEN'(cause_i);
        IDX_EPC:    rdata_o = epc_i;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit #(
  parameter int              XLEN         = 32,
  parameter int              NUM_SRC      = 4,
  parameter int              CAUSE_W      = 4,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0080
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SRC-1:0]           exc_req_i,
  input  logic [NUM_SRC*CAUSE_W-1:0]   exc_cause_i,
  input  logic [XLEN-1:0]              exc_pc_i,
  input  logic [XLEN-1:0]              exc_vaddr_i,
  input  logic [1:0]                   op_i,
  input  logic [exc_pkg::CP_IDX_W-1:0] cp_idx_i,
  input  logic [XLEN-1:0]              cp_wdata_i,
  output logic                         redirect_o,
  output logic [XLEN-1:0]              redirect_pc_o,
  output logic [XLEN-1:0]              rdata_o,
  output logic                         priv_o,
  output logic                         priv_viol_o
);
  import exc_pkg::*;

  sys_op_e            op;
  logic               ext_hit, take, wr_mask, rfe_do, viol, rd_en;
  logic [CAUSE_W-1:0] ext_cause, take_cause, cause_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [XLEN-1:0]    epc_q, vaddr_q;
  logic               unused_wdata;

  assign op           = sys_op_e'(op_i);
  assign unused_wdata = ^cp_wdata_i[XLEN-1:NUM_SRC];

  assign viol       = (op != OP_NONE) && !priv_o;
  assign take       = viol || ext_hit;
  assign take_cause = viol ? CAUSE_W'(CAUSE_ILLEGAL) : ext_cause;
  assign wr_mask    = !take && (op == OP_MTC0) && (cp_idx_i == IDX_STATUS);
  assign rfe_do     = !take && (op == OP_RFE);
  assign rd_en      = (op == OP_MFC0) && priv_o;

  assign priv_viol_o   = viol;
  assign redirect_o    = take || rfe_do;
  assign redirect_pc_o = take ? HANDLER_ADDR : epc_q;

  exc_pick #(.NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W)) u_pick (
    .req_i    (exc_req_i),
    .causes_i (exc_cause_i),
    .mask_i   (mask_q),
    .hit_o    (ext_hit),
    .cause_o  (ext_cause)
  );

  exc_state #(.XLEN(XLEN), .NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .take_cause_i (take_cause),
    .pc_i         (exc_pc_i),
    .vaddr_i      (exc_vaddr_i),
    .wr_mask_i    (wr_mask),
    .wdata_mask_i (cp_wdata_i[NUM_SRC-1:0]),
    .rfe_i        (rfe_do),
    .priv_o       (priv_o),
    .mask_o       (mask_q),
    .cause_o      (cause_q),
    .epc_o        (epc_q),
    .vaddr_o      (vaddr_q)
  );

  exc_rdmux #(.XLEN(XLEN), .NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W)) u_rdmux (
    .en_i    (rd_en),
    .idx_i   (cp_idx_i),
    .priv_i  (priv_o),
    .mask_i  (mask_q),
    .cause_i (cause_q),
    .epc_i   (epc_q),
    .vaddr_i (vaddr_q),
    .rdata_o (rdata_o)
  );

  // R10
  user_op_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_viol_o |-> (redirect_o && redirect_pc_o == HANDLER_ADDR && rdata_o == '0));
  // R10
  user_op_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_viol_o |=> (priv_o && cause_q == CAUSE_W'(CAUSE_ILLEGAL)));
  // R4
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_NONE && (exc_req_i & mask_q) == '0) |-> !redirect_o);
  // R7
  no_read_leak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_MFC0) |-> rdata_o == '0);
endmodule

// File: tb/sim_exc_ctrl_unit.sv
`timescale 1ns/1ps
module sim_exc_ctrl_unit;
  localparam logic [31:0] HANDLER = 32'h8000_0080;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  exc_req_i = '0;
  logic [15:0] exc_cause_i = {4'd0, 4'd4, 4'd8, 4'd12};
  logic [31:0] exc_pc_i = '0, exc_vaddr_i = '0, cp_wdata_i = '0;
  logic [1:0]  op_i = '0;
  logic [4:0]  cp_idx_i = '0;
  logic        redirect_o, priv_o, priv_viol_o;
  logic [31:0] redirect_pc_o, rdata_o;

  int n_chk = 0, n_fail = 0;

  exc_ctrl_unit u0 (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] op, input logic [4:0] idx, input logic [31:0] wd,
                     input logic [3:0] req, input logic [31:0] pc, input logic [31:0] va);
    @(negedge clk_i);
    op_i = op; cp_idx_i = idx; cp_wdata_i = wd;
    exc_req_i = req; exc_pc_i = pc; exc_vaddr_i = va;
    #1;
  endtask

  task automatic tick;
    @(posedge clk_i);
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] d);
    put(2'd1, idx, '0, '0, '0, '0);
    d = rdata_o;
    tick();
  endtask

  function automatic logic [3:0] line_cause(input int i);
    return exc_cause_i[i*4 +: 4];
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, e_epc, e_va;
    logic [3:0]  e_cause;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    #1 chk("R1 priv", {31'd0, priv_o}, 32'd1);
    rd(5'd12, d); chk("R1 status", d, 32'h8000_000F);
    rd(5'd13, d); chk("R1 cause", d, 0);
    rd(5'd14, d); chk("R1 epc", d, 0);
    rd(5'd8,  d); chk("R1 vaddr", d, 0);
    // R7 unimplemented indices
    rd(5'd0,  d); chk("R7 idx0", d, 0);
    rd(5'd31, d); chk("R7 idx31", d, 0);
    rd(5'd9,  d); chk("R7 idx9", d, 0);

    // R8 read-only indices ignore writes
    put(2'd2, 5'd13, 32'hFFFF_FFFF, 0, 0, 0); chk("R8 no viol", {31'd0, priv_viol_o}, 0); tick();
    put(2'd2, 5'd14, 32'hFFFF_FFFF, 0, 0, 0); tick();
    put(2'd2, 5'd8,  32'hFFFF_FFFF, 0, 0, 0); tick();
    rd(5'd13, d); chk("R8 cause ro", d, 0);
    rd(5'd14, d); chk("R8 epc ro", d, 0);
    rd(5'd8,  d); chk("R8 vaddr ro", d, 0);
    put(2'd2, 5'd12, 32'h0000_0005, 0, 0, 0); tick();
    rd(5'd12, d); chk("R8 mask write", d, 32'h8000_0005);

    // exhaustive mask x request sweep
    e_cause = 0; e_epc = 0; e_va = 0;
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 16; r++) begin
        logic [31:0] pc, va;
        int sel;
        sel = -1;
        for (int i = 3; i >= 0; i--) if (r[i] && m[i]) sel = i;
        pc = 32'h1000_0000 | (32'(m * 16 + r) << 2);
        va = 32'hBAD0_0000 | 32'(m * 16 + r);
        put(2'd2, 5'd12, 32'(m), 0, 0, 0); tick();
        put(2'd0, 5'd0, 0, 4'(r), pc, va);
        if (sel >= 0) begin
          chk("R2 redirect", {31'd0, redirect_o}, 1);
          chk("R2 target", redirect_pc_o, HANDLER);
          e_cause = line_cause(sel);
          e_epc = pc;
          if (e_cause == 4'd4) e_va = va;
        end else begin
          chk("R4 masked no redirect", {31'd0, redirect_o}, 0);
        end
        tick();
        rd(5'd13, d); chk("R3 cause", d, {28'd0, e_cause});
        rd(5'd14, d); chk("R5 epc", d, e_epc);
        rd(5'd8,  d); chk("R6 vaddr", d, e_va);
        rd(5'd12, d); chk("R7 status", d, 32'h8000_0000 | 32'(m));
      end
    end

    // R9 return from exception
    put(2'd2, 5'd12, 32'hF, 0, 0, 0); tick();
    put(2'd0, 5'd0, 0, 4'b0010, 32'h0000_4444, 0); tick();
    put(2'd3, 5'd0, 0, 0, 0, 0);
    chk("R9 redirect", {31'd0, redirect_o}, 1);
    chk("R9 target", redirect_pc_o, 32'h0000_4444);
    tick();
    put(2'd0, 5'd0, 0, 0, 0, 0);
    chk("R9 user mode", {31'd0, priv_o}, 0);

    // R10 read in user mode traps
    put(2'd1, 5'd12, 0, 0, 32'h0000_5550, 0);
    chk("R10 viol", {31'd0, priv_viol_o}, 1);
    chk("R10 rdata zero", rdata_o, 0);
    chk("R10 redirect", redirect_pc_o, HANDLER);
    tick();
    put(2'd0, 5'd0, 0, 0, 0, 0);
    chk("R10 priv after trap", {31'd0, priv_o}, 1);
    rd(5'd13, d); chk("R10 cause", d, 10);
    rd(5'd14, d); chk("R10 epc", d, 32'h0000_5550);

    // R10 user write with concurrent request: illegal wins, mask intact
    put(2'd3, 5'd0, 0, 0, 0, 0); tick();
    put(2'd2, 5'd12, 32'h0, 4'b0001, 32'h0000_6660, 0);
    chk("R10 viol write", {31'd0, priv_viol_o}, 1);
    tick();
    rd(5'd13, d); chk("R10 cause over line", d, 10);
    rd(5'd12, d); chk("R10 mask intact", d, 32'h8000_000F);
    rd(5'd14, d); chk("R10 epc write", d, 32'h0000_6660);

    // R11 exception suppresses concurrent return and write
    put(2'd3, 5'd0, 0, 4'b0010, 32'h0000_7770, 0);
    chk("R11 target", redirect_pc_o, HANDLER);
    tick();
    put(2'd0, 5'd0, 0, 0, 0, 0);
    chk("R11 stays priv", {31'd0, priv_o}, 1);
    put(2'd2, 5'd12, 32'h0, 4'b1000, 32'h0000_8880, 0); tick();
    rd(5'd12, d); chk("R11 mask kept", d, 32'h8000_000F);
    rd(5'd13, d); chk("R11 cause", d, 0);
    rd(5'd14, d); chk("R11 epc", d, 32'h0000_8880);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule